// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a single-clock model of a burst-capable static memory. Each word has four byte lanes, and each lane holds eight data bits and one parity bit. The model stores whatever parity the host drives and does not generate or check it. A host starts an access with one of two address strobes, a processor strobe or a controller strobe. The processor strobe has fixed priority over the controller strobe. Three chip enables, two active low and one active high, decide whether the device is selected. They are sampled only when an address is loaded, so the selection stays in force for the rest of the burst.

The two low address bits go into a counter that steps through a four-word group in linear order while the advance input is held low. Writes can cover all lanes through the global write input. They can also cover selected lanes through the byte-write enable and the per-lane selects. Read data is registered and goes out on a bidirectional bus. An asynchronous output enable controls that bus. The output is masked for one cycle on the first read after the device has been deselected. A sleep input freezes all activity and keeps the stored contents.

The depth is set by `ADDR_W`, which defaults to 10. Setting it to 16 gives a 64K-word array.

Top module: `ssram_burst_top`

## Requirements
- R1: After synchronous reset the device is deselected, its bus is not driven, and it keeps driving nothing until a new read access is made.
- R2: An address is loaded at a rising edge when a strobe is accepted. The device is selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at that edge. Otherwise it becomes deselected, performs no access and leaves the bus undriven.
- R3: When both strobes are low and `ce1_n` is low, only the processor strobe acts. That cycle is always a read, and all write inputs are ignored.
- R4: While `ce1_n` is high, a low processor strobe is ignored. With the controller strobe high, a running burst continues as if no strobe were present.
- R5: When no strobe is accepted, the chip enables are not re-evaluated, and an active burst continues.
- R6: On load, the counter takes `addr[1:0]`. In non-load cycles, `adv_n`=0 steps it by one modulo 4 (for example 2,3,0,1), and `adv_n`=1 holds it. The accessed word is the registered upper address bits joined with the counter.
- R7: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` are.
- R8: With `gw_n`=1 and `bwe_n`=0, lane i (`dq[8i+7:8i]` plus `dqp[i]`) is written exactly when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, nothing is written and the cycle is a read.
- R9: A controller-strobe load cycle with a write request writes the new address. A non-load cycle with a write request writes the current burst address, after any advance in that cycle.
- R10: After a rising edge that performs a read, the bus drives the word read at that edge while `oe_n` is low.
- R11: `oe_n`=1 puts `dq` and `dqp` in high impedance at once, with no clock edge needed.
- R12: For the cycle after the first read that follows a deselected state, the bus is not driven, whatever `oe_n` is.
- R13: While `zz`=1, the address, counter, selection and read data hold, no write takes place, and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor address strobe, active low, higher priority |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| dq | inout | LANES*BYTE_W | Data bus, lane i at bits [8i+7:8i] |
| dqp | inout | LANES | Parity bus, one bit per lane |

## Verification
The bench drives both strobes low together while a write is requested. A model that let the controller strobe win would overwrite the word instead of returning its old contents. It runs a burst from an offset of 2 and steps it past the group boundary. A counter that carried into the upper bits would fetch a word from the next group. The bench also reads immediately after a deselect, changes the chip enables in the middle of a burst, and attempts a write while asleep. The expected faults are an early bus drive, a burst cut short, or a word that changed while the device was frozen. Partial byte masks check that lanes with their select high keep their old data and parity.

// File: rtl/ssram_burst_pkg.sv
package ssram_burst_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } strobe_src_e;
endpackage

// File: rtl/ssram_addr_ctl.sv
module ssram_addr_ctl
  import ssram_burst_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zz,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid,
  output logic              proc_load,
  output logic              active_q,
  output logic [1:0]        cnt_q
);
  localparam int UP_W = ADDR_W - 2;

  strobe_src_e      src;
  logic             load;
  logic             sel_ok;
  logic [1:0]       nxt_cnt;
  logic [UP_W-1:0]  upper_q;

  // fixed priority: processor strobe only counts while ce1_n is low
  always_comb begin
    if (!adsp_n && !ce1_n)  src = SRC_PROC;
    else if (!adsc_n)       src = SRC_CTRL;
    else                    src = SRC_NONE;
  end

  assign load      = (src != SRC_NONE);
  assign proc_load = (src == SRC_PROC);
  assign sel_ok    = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (load)        nxt_cnt = addr_i[1:0];
    else if (!adv_n) nxt_cnt = cnt_q + 2'd1;
    else             nxt_cnt = cnt_q;
  end

  assign acc_addr  = load ? addr_i : {upper_q, nxt_cnt};
  assign acc_valid = !zz && (load ? sel_ok : active_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      upper_q  <= '0;
      cnt_q    <= 2'd0;
    end else if (!zz) begin
      if (load) begin
        active_q <= sel_ok;
        if (sel_ok) begin
          upper_q <= addr_i[ADDR_W-1:2];
          cnt_q   <= addr_i[1:0];
        end
      end else if (active_q) begin
        cnt_q <= nxt_cnt;
      end
    end
  end
endmodule

// File: rtl/ssram_wr_dec.sv
module ssram_wr_dec #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_req
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_req[i] = !gw_n || (!bwe_n && !bw_n[i]);
  end
endmodule

// File: rtl/ssram_lane_ram.sv
module ssram_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // read-first single port, suitable for block RAM inference
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/ssram_burst_top.sv
module ssram_burst_top #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic              zz,
  inout  wire [LANES*BYTE_W-1:0] dq,
  inout  wire [LANES-1:0]   dqp
);
  localparam int LANE_W = BYTE_W + 1;

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_valid;
  logic              proc_load;
  logic              active_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  lane_req;
  logic [LANES-1:0]  lane_we;
  logic              is_write;
  logic              rd_access;
  logic              rd_valid_q;
  logic              mask_q;
  logic              drive_en;
  logic [LANE_W-1:0] lane_rdata [LANES];

  ssram_addr_ctl #(.ADDR_W(ADDR_W)) u_actl (
    .clk      (clk),
    .rst      (rst),
    .zz       (zz),
    .addr_i   (addr),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .acc_addr (acc_addr),
    .acc_valid(acc_valid),
    .proc_load(proc_load),
    .active_q (active_q),
    .cnt_q    (cnt_q)
  );

  ssram_wr_dec #(.LANES(LANES)) u_wdec (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .lane_req(lane_req)
  );

  // a processor-strobe load is always a read
  assign is_write  = acc_valid && !proc_load && (|lane_req);
  assign rd_access = acc_valid && !is_write;
  assign lane_we   = is_write ? lane_req : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      mask_q     <= 1'b0;
    end else if (!zz) begin
      rd_valid_q <= rd_access;
      mask_q     <= rd_access && !active_q;
    end
  end

  assign drive_en = !oe_n && !zz && rd_valid_q && !mask_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] wdata;
    assign wdata = {dqp[i], dq[i*BYTE_W +: BYTE_W]};

    ssram_lane_ram #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_ram (
      .clk  (clk),
      .en   (acc_valid),
      .we   (lane_we[i]),
      .addr (acc_addr),
      .wdata(wdata),
      .rdata(lane_rdata[i])
    );

    assign dq[i*BYTE_W +: BYTE_W] = drive_en ? lane_rdata[i][BYTE_W-1:0] : 'z;
    assign dqp[i]                 = drive_en ? lane_rdata[i][BYTE_W]     : 1'bz;
  end
endmodule

// File: rtl/ssram_burst_chk.sv
module ssram_burst_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             zz,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             adv_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic [1:0]       addr_lo,
  input logic             active_q,
  input logic [1:0]       cnt_q,
  input logic [LANES-1:0] lane_we,
  input logic             mask_q,
  input logic             drive_en
);
  logic strobe_eff;
  logic enables_ok;
  assign strobe_eff = (!adsp_n && !ce1_n) || !adsc_n;
  assign enables_ok = !ce1_n && ce2 && !ce3_n;

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!zz && strobe_eff && enables_ok) |=> (active_q && cnt_q == $past(addr_lo))); // R2
  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (!zz && strobe_eff && !enables_ok) |=> !active_q); // R2
  AST_PROC_READS: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !ce1_n) |-> (lane_we == '0)); // R3
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!zz && !strobe_eff && active_q) |=> active_q); // R5
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!zz && !strobe_eff && active_q && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1))); // R6
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!zz && !strobe_eff && adv_n) |=> $stable(cnt_q)); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !drive_en); // R12
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    zz |=> ($stable(cnt_q) && $stable(active_q))); // R13
  AST_SLEEP_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    zz |-> (lane_we == '0 && !drive_en)); // R13
endmodule

bind ssram_burst_top ssram_burst_chk #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .zz      (zz),
  .adsp_n  (adsp_n),
  .adsc_n  (adsc_n),
  .adv_n   (adv_n),
  .ce1_n   (ce1_n),
  .ce2     (ce2),
  .ce3_n   (ce3_n),
  .addr_lo (addr[1:0]),
  .active_q(active_q),
  .cnt_q   (cnt_q),
  .lane_we (lane_we),
  .mask_q  (mask_q),
  .drive_en(drive_en)
);

// File: tb/ssram_burst_top_test.sv
module ssram_burst_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NL = 4;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n;
  logic          gw_n, bwe_n, oe_n, zz;
  logic [NL-1:0] bw_n;
  logic          tb_en;
  logic [31:0]   tb_d;
  logic [3:0]    tb_p;
  wire  [31:0]   dq;
  wire  [3:0]    dqp;

  logic [35:0]   shadow [64];
  int            n_checks = 0;
  int            n_fails  = 0;

  assign dq  = tb_en ? tb_d : 'z;
  assign dqp = tb_en ? tb_p : 'z;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssram_burst_top #(.ADDR_W(AW), .LANES(NL), .BYTE_W(8)) uut (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .dq(dq), .dqp(dqp)
  );

  function automatic logic [35:0] pat(int a, int salt);
    return {4'(a ^ salt ^ 5), 8'(a * 3 + 1 + salt), 8'hC3 ^ 8'(salt),
            8'(a + 17), 8'h96 ^ 8'(a)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = '1; zz = 0; tb_en = 0;
  endtask

  task automatic check_bus(string req, int a);
    n_checks++;
    if ({dqp, dq} !== shadow[a]) begin
      n_fails++;
      $display("FAIL %s: word %0d actual %h expected %h", req, a, {dqp, dq}, shadow[a]);
    end
  endtask

  task automatic check_quiet(string req, int a);
    n_checks++;
    if ({dqp, dq} === shadow[a]) begin
      n_fails++;
      $display("FAIL %s: bus driven, actual %h expected not %h", req, {dqp, dq}, shadow[a]);
    end
  endtask

  task automatic ctrl_write(int a, logic [35:0] w);
    idle(); oe_n = 1; adsc_n = 0; addr = AW'(a); gw_n = 0;
    tb_en = 1; {tb_p, tb_d} = w;
    tick(); idle();
    shadow[a] = w;
  endtask

  task automatic ctrl_read(int a);
    idle(); oe_n = 0; adsc_n = 0; addr = AW'(a);
    tick(); idle();
  endtask

  task automatic proc_read(int a);
    idle(); oe_n = 0; adsp_n = 0; addr = AW'(a);
    tick(); idle();
  endtask

  task automatic t_reset();   // R1
    ctrl_read(5);
    check_bus("R10", 5);
    rst = 1; tick(); rst = 0;
    check_quiet("R1", 5);
    tick();
    check_quiet("R1", 5);
  endtask

  task automatic t_mask();    // R12, R2
    proc_read(3);
    check_quiet("R12", 3);
    tick();
    check_bus("R12", 3);
    idle(); oe_n = 0; adsc_n = 0; ce2 = 0; addr = 7; tick(); idle();
    check_quiet("R2", 7);
    tick();
    check_quiet("R2", 3);
    idle(); adsp_n = 0; ce3_n = 1; addr = 8; tick(); idle();
    check_quiet("R2", 8);
    proc_read(3);
    check_quiet("R12", 3);
    tick();
    check_bus("R12", 3);
  endtask

  task automatic t_priority(); // R3
    idle(); oe_n = 1; adsp_n = 0; adsc_n = 0; addr = 9; gw_n = 0;
    tb_en = 1; {tb_p, tb_d} = ~shadow[9];
    tick(); idle(); oe_n = 0; #1;
    check_bus("R3", 9);
    ctrl_write(10, pat(10, 77));
    ctrl_read(10);
    check_bus("R9", 10);
  endtask

  task automatic t_ce_rules(); // R4, R5
    ctrl_read(12);
    check_bus("R10", 12);
    adsp_n = 0; ce1_n = 1; addr = 40; adv_n = 0; tick(); idle();
    check_bus("R4", 13);
    ce2 = 0; ce3_n = 1; adv_n = 0; tick(); idle();
    check_bus("R5", 14);
  endtask

  task automatic t_burst();   // R6
    proc_read(6);
    check_bus("R6", 6);
    adv_n = 0; tick(); check_bus("R6", 7);
    tick(); check_bus("R6", 4);
    tick(); check_bus("R6", 5);
    adv_n = 1; tick(); check_bus("R6", 5);
    idle();
  endtask

  task automatic t_writes();  // R7, R8, R9
    logic [35:0] w;
    idle(); oe_n = 1; adsc_n = 0; addr = 22; gw_n = 0; bwe_n = 1; bw_n = '1;
    w = pat(22, 200); tb_en = 1; {tb_p, tb_d} = w;
    tick(); idle(); shadow[22] = w;
    ctrl_read(22); check_bus("R7", 22);

    idle(); oe_n = 1; adsc_n = 0; addr = 20; bwe_n = 0; bw_n = 4'b1010;
    w = pat(20, 99); tb_en = 1; {tb_p, tb_d} = w;
    tick(); idle();
    for (int i = 0; i < 4; i++) begin
      if (i == 0 || i == 2) begin
        shadow[20][i*8 +: 8] = w[i*8 +: 8];
        shadow[20][32+i]     = w[32+i];
      end
    end
    ctrl_read(20); check_bus("R8", 20);

    idle(); oe_n = 1; adsc_n = 0; addr = 21; bwe_n = 1; bw_n = '0;
    tb_en = 1; {tb_p, tb_d} = ~shadow[21];
    tick(); idle(); oe_n = 0; #1;
    check_bus("R8", 21);

    ctrl_read(24);
    oe_n = 1; adv_n = 0; bwe_n = 0; bw_n = '0;
    w = pat(25, 51); tb_en = 1; {tb_p, tb_d} = w;
    tick(); idle(); shadow[25] = w;
    ctrl_read(25); check_bus("R9", 25);

    proc_read(28);
    oe_n = 1; gw_n = 0; w = pat(28, 33); tb_en = 1; {tb_p, tb_d} = w;
    tick(); idle(); shadow[28] = w;
    ctrl_read(28); check_bus("R9", 28);
  endtask

  task automatic t_oe();      // R11
    ctrl_read(30);
    check_bus("R10", 30);
    oe_n = 1; #1; check_quiet("R11", 30);
    oe_n = 0; #1; check_bus("R11", 30);
  endtask

  task automatic t_sleep();   // R13
    ctrl_read(32);
    check_bus("R10", 32);
    zz = 1; #1; check_quiet("R13", 32);
    oe_n = 1; adv_n = 0; gw_n = 0; tb_en = 1; {tb_p, tb_d} = ~shadow[33];
    tick(); tick();
    idle(); oe_n = 0; #1;
    check_bus("R13", 32);
    adv_n = 0; tick(); idle();
    check_bus("R13", 33);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog (R1-related run): actual %0d cycles expected fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle(); oe_n = 1; addr = '0; tb_d = '0; tb_p = '0;
    rst = 1; tick(); tick(); rst = 0;
    for (int a = 0; a < 64; a++) ctrl_write(a, pat(a, 0));
    t_reset();
    t_mask();
    t_priority();
    t_ce_rules();
    t_burst();
    t_writes();
    t_oe();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule